// File: doc/BRIEF.md
# Index/Data Configuration Port Controller

This block gives a host access to a set of configuration registers through two byte-wide I/O ports on a simple bus. The bus has an address, a write strobe, a read strobe, write data and read data. After power-up the register space is closed. A host opens it by writing a fixed key byte twice in a row to the base port.

Once the space is open, a write to the base port loads an index register. The data port at base+1 then reads or writes the register that the index selects. Some registers are global. Others sit in banks chosen by a logical-device number, which is held in a global select register. A lock bit in a global register protects the space against stray writes. A cold reset returns every register to its default. A warm reset only closes the space and clears the index.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The base port is at address 2Eh when `strap_alt` is 0 and at 4Eh when it is 1. The data port is the base port plus one. Accesses to any other address never reach the registers.
- R2: Two successive bus cycles that both write 87h to the base port open the configuration space. Idle cycles with no strobe may separate them.
- R3: If one 87h base write has been seen, any other bus cycle (a read, a write of another value, or a write to another address) cancels it. A new pair of 87h writes is then needed.
- R4: While the space is open, writing AAh to the base port closes it, and that write does not load the index.
- R5: While the space is closed, writes to the base and data ports leave the index and all registers unchanged, and every read returns FFh.
- R6: While open, a base-port write loads the index. A data-port access then reads or writes the selected register. Implemented global registers are at indices 02h, 07h and 20h–2Fh.
- R7: Index 07h holds the logical-device number. Indices 30h–3Fh reach a separate 16-byte bank for each of devices 0–7. Writing one bank leaves the other banks unchanged. With a device number of 8 or more, banked indices read 00h and ignore writes.
- R8: Indices that are not implemented (00h, 01h, 03h–06h, 08h–1Fh, 40h–FFh) read 00h and ignore writes.
- R9: While bit 5 of register 26h is 1, data-port writes to every register except 26h are ignored. Register 26h stays writable, so the lock can be released.
- R10: A warm reset closes the space and sets the index to 00h but keeps all register contents. A cold reset also clears every register to 00h.
- R11: `io_rdata` reads FFh after either reset. It is updated only at a clock edge where `io_rd` is high, and it holds its value between reads. A data-port read while open returns the selected register. Any other read returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low cold reset; clears everything |
| warm_rst_n | input | 1 | Active-low warm reset; closes the space and clears the index |
| strap_alt | input | 1 | Base port select: 0 gives 2Eh, 1 gives 4Eh |
| io_addr | input | ADDR_W (16) | Bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |

## Verification
The bench interrupts a half-finished unlock with a read, and also with a write to a foreign address. A design that only watched base-port writes would open early and return register data where FFh is expected. It moves the base port with the strap and confirms the old port pair goes dead, catching a decoder tied to one address. It sets the lock and writes the select register, a global register and the lock register itself, which separates a lock that blocks nothing, blocks everything, or can never be cleared. It also checks that bank data survives a switch between devices and an out-of-range device number, and that a warm reset keeps register contents while a cold reset clears them.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

   typedef enum logic [1:0] {
      ST_SHUT = 2'd0,
      ST_HALF = 2'd1,
      ST_OPEN = 2'd2
   } gate_st_e;

   localparam logic [7:0] CFG_OPEN_KEY  = 8'h87;
   localparam logic [7:0] CFG_CLOSE_KEY = 8'hAA;
   localparam logic [7:0] CFG_IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
   import cfg_pkg::*;
#(
   parameter logic [7:0] OPEN_KEY  = CFG_OPEN_KEY,
   parameter logic [7:0] CLOSE_KEY = CFG_CLOSE_KEY
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_cycle,
   input  logic       base_wr,
   input  logic [7:0] wdata,
   output logic       cfg_open
);

   gate_st_e st_q, st_d;
   logic     key_wr;

   assign key_wr = base_wr && (wdata == OPEN_KEY);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_SHUT: if (key_wr) st_d = ST_HALF;
         ST_HALF: if (bus_cycle) st_d = key_wr ? ST_OPEN : ST_SHUT;
         ST_OPEN: if (base_wr && (wdata == CLOSE_KEY)) st_d = ST_SHUT;
         default: st_d = ST_SHUT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_SHUT;
      else        st_q <= st_d;
   end

   assign cfg_open = (st_q == ST_OPEN);

   // R2
   open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_OPEN) |-> ($past(st_q) == ST_HALF) && $past(key_wr));

   // R3
   half_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALF && bus_cycle && !key_wr) |=> (st_q == ST_SHUT));

   // R4
   close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && base_wr && wdata == CLOSE_KEY) |=> !cfg_open);

endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs #(
   parameter int NUM_LDEV = 8,
   parameter int AUX_IDX  = 'h02,
   parameter int LDEV_IDX = 'h07,
   parameter int GLOB_LO  = 'h20,
   parameter int GLOB_N   = 16,
   parameter int BANK_LO  = 'h30,
   parameter int BANK_N   = 16,
   parameter int LOCK_IDX = 'h26,
   parameter int LOCK_BIT = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);

   localparam int         GOFF_W   = (GLOB_N > 1) ? $clog2(GLOB_N) : 1;
   localparam int         BOFF_W   = (BANK_N > 1) ? $clog2(BANK_N) : 1;
   localparam int         DEV_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
   localparam logic [8:0] GLOB_END = 9'(GLOB_LO + GLOB_N);
   localparam logic [8:0] BANK_END = 9'(BANK_LO + BANK_N);
   localparam logic [7:0] GLOB_LO8 = 8'(GLOB_LO);
   localparam logic [7:0] BANK_LO8 = 8'(BANK_LO);
   localparam logic [7:0] AUX8     = 8'(AUX_IDX);
   localparam logic [7:0] LDEV8    = 8'(LDEV_IDX);
   localparam logic [7:0] LOCK8    = 8'(LOCK_IDX);
   localparam int         LOCK_OFF = LOCK_IDX - GLOB_LO;

   if (GLOB_LO + GLOB_N > BANK_LO) begin : g_bad_glob
      $error("global range overlaps banked range");
   end
   if (BANK_LO + BANK_N > 256) begin : g_bad_bank
      $error("banked range exceeds index space");
   end
   if (LOCK_IDX < GLOB_LO || LOCK_IDX >= GLOB_LO + GLOB_N || LOCK_BIT > 7) begin : g_bad_lock
      $error("lock register must be an implemented global");
   end
   if (NUM_LDEV < 2 || NUM_LDEV > 256) begin : g_bad_ldev
      $error("device count out of range");
   end

   logic [GLOB_N-1:0][7:0] glob_q;
   logic [BANK_N-1:0][7:0] bank_q [NUM_LDEV];
   logic [7:0]             aux_q, ldev_q;
   logic                   glob_hit, bank_hit, dev_ok, lock_on, wr_ok;
   logic [GOFF_W-1:0]      goff;
   logic [BOFF_W-1:0]      boff;
   logic [DEV_W-1:0]       dev;

   assign glob_hit = ({1'b0, idx} >= 9'(GLOB_LO)) && ({1'b0, idx} < GLOB_END);
   assign bank_hit = ({1'b0, idx} >= 9'(BANK_LO)) && ({1'b0, idx} < BANK_END);
   assign goff     = GOFF_W'(idx - GLOB_LO8);
   assign boff     = BOFF_W'(idx - BANK_LO8);
   assign dev_ok   = ({1'b0, ldev_q} < 9'(NUM_LDEV));
   assign dev      = DEV_W'(ldev_q);
   assign lock_on  = glob_q[LOCK_OFF][LOCK_BIT];
   assign wr_ok    = wr_en && (!lock_on || idx == LOCK8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= '0;
         aux_q  <= '0;
         ldev_q <= '0;
      end else if (wr_ok) begin
         if (idx == AUX8)  aux_q  <= wdata;
         if (idx == LDEV8) ldev_q <= wdata;
         if (glob_hit)     glob_q[goff] <= wdata;
      end
   end

   for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
      logic sel;
      assign sel = wr_ok && bank_hit && dev_ok && (dev == DEV_W'(d));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   bank_q[d] <= '0;
         else if (sel) bank_q[d][boff] <= wdata;
      end

      // R9
      bank_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && lock_on && idx != LOCK8) |=> $stable(bank_q[d]));
   end

   always_comb begin
      rdata = '0;
      if (idx == AUX8)              rdata = aux_q;
      else if (idx == LDEV8)        rdata = ldev_q;
      else if (glob_hit)            rdata = glob_q[goff];
      else if (bank_hit && dev_ok)  rdata = bank_q[dev][boff];
   end

   // R9
   glob_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_on && idx != LOCK8) |=> $stable(glob_q) && $stable(aux_q) && $stable(ldev_q));

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
   import cfg_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BASE_PRI = 'h2E,
   parameter int BASE_ALT = 'h4E,
   parameter int NUM_LDEV = 8,
   parameter int GLOB_N   = 16,
   parameter int BANK_N   = 16
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata
);

   localparam logic [ADDR_W-1:0] PRI_A = ADDR_W'(BASE_PRI);
   localparam logic [ADDR_W-1:0] ALT_A = ADDR_W'(BASE_ALT);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("address width too small for port map");
   end

   logic              rst_any_n, cfg_open, hit_base, hit_data, base_wr, rf_wr;
   logic [ADDR_W-1:0] base_a;
   logic [7:0]        idx_q, rf_rdata;

   assign rst_any_n = cold_rst_n & warm_rst_n;
   assign base_a    = strap_alt ? ALT_A : PRI_A;
   assign hit_base  = (io_addr == base_a);
   assign hit_data  = (io_addr == base_a + ADDR_W'(1));
   assign base_wr   = io_wr && hit_base;
   assign rf_wr     = cfg_open && io_wr && hit_data;

   cfg_unlock_fsm u_gate (
      .clk       (clk),
      .rst_n     (rst_any_n),
      .bus_cycle (io_wr | io_rd),
      .base_wr   (base_wr),
      .wdata     (io_wdata),
      .cfg_open  (cfg_open)
   );

   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n)
         idx_q <= '0;
      else if (cfg_open && base_wr && io_wdata != CFG_CLOSE_KEY)
         idx_q <= io_wdata;
   end

   cfg_bank_regs #(
      .NUM_LDEV (NUM_LDEV),
      .GLOB_N   (GLOB_N),
      .BANK_N   (BANK_N)
   ) u_regs (
      .clk   (clk),
      .rst_n (cold_rst_n),
      .wr_en (rf_wr),
      .idx   (idx_q),
      .wdata (io_wdata),
      .rdata (rf_rdata)
   );

   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n)
         io_rdata <= CFG_IDLE_BYTE;
      else if (io_rd)
         io_rdata <= (cfg_open && hit_data) ? rf_rdata : CFG_IDLE_BYTE;
   end

   // R5
   shut_read_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
      (io_rd && !cfg_open) |=> (io_rdata == CFG_IDLE_BYTE));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
      !io_rd |=> $stable(io_rdata));

   // R5
   shut_index_chk: assert property (@(posedge clk) disable iff (!rst_any_n)
      !cfg_open |=> $stable(idx_q));

endmodule

// File: tb/cfg_port_ctrl_test.sv
module cfg_port_ctrl_test;

   logic        clk = 1'b0;
   logic        cold_rst_n = 1'b0;
   logic        warm_rst_n = 1'b0;
   logic        strap_alt = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfg_port_ctrl uut (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .warm_rst_n (warm_rst_n),
      .strap_alt  (strap_alt),
      .io_addr    (io_addr),
      .io_wr      (io_wr),
      .io_rd      (io_rd),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic open_at(input logic [15:0] b);
      bus_wr(b, 8'h87);
      bus_wr(b, 8'h87);
   endtask

   task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
      bus_wr(16'h002E, i);
      bus_wr(16'h002F, d);
   endtask

   task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
      bus_wr(16'h002E, i);
      bus_rd(16'h002F, d);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R11 reset value", io_rdata, 8'hFF);
      bus_wr(16'h002E, 8'h20);
      bus_wr(16'h002F, 8'h5A);
      bus_rd(16'h002F, v);
      check("R5 closed read", v, 8'hFF);
   endtask

   task automatic t_global;
      logic [7:0] v;
      open_at(16'h002E);
      bus_rd(16'h002F, v);
      check("R5 closed write ignored (index 00)", v, 8'h00);
      reg_wr(8'h20, 8'h00);
      reg_wr(8'h20, 8'hA5);
      reg_rd(8'h20, v);
      check("R6 global 20h", v, 8'hA5);
      reg_wr(8'h02, 8'h3C);
      reg_rd(8'h02, v);
      check("R6 global 02h", v, 8'h3C);
      reg_wr(8'h2F, 8'hC3);
      reg_rd(8'h2F, v);
      check("R6 global 2Fh", v, 8'hC3);
      repeat (3) @(negedge clk);
      check("R11 hold idle", io_rdata, 8'hC3);
      bus_wr(16'h002E, 8'h20);
      check("R11 hold after write", io_rdata, 8'hC3);
   endtask

   task automatic t_unimpl;
      logic [7:0] v;
      reg_wr(8'h05, 8'h77);
      reg_rd(8'h05, v);
      check("R8 index 05h", v, 8'h00);
      reg_wr(8'h40, 8'h77);
      reg_rd(8'h40, v);
      check("R8 index 40h", v, 8'h00);
      reg_wr(8'h1F, 8'h77);
      reg_rd(8'h1F, v);
      check("R8 index 1Fh", v, 8'h00);
      reg_rd(8'h20, v);
      check("R8 no side write", v, 8'hA5);
   endtask

   task automatic t_banked;
      logic [7:0] v;
      reg_wr(8'h07, 8'h00);
      reg_wr(8'h30, 8'h11);
      reg_wr(8'h07, 8'h07);
      reg_wr(8'h30, 8'h22);
      reg_rd(8'h30, v);
      check("R7 dev7 30h", v, 8'h22);
      reg_wr(8'h3F, 8'h33);
      reg_rd(8'h3F, v);
      check("R7 dev7 3Fh", v, 8'h33);
      reg_wr(8'h07, 8'h00);
      reg_rd(8'h30, v);
      check("R7 dev0 kept", v, 8'h11);
      reg_rd(8'h3F, v);
      check("R7 dev0 separate", v, 8'h00);
      reg_wr(8'h07, 8'h09);
      reg_rd(8'h07, v);
      check("R7 select readback", v, 8'h09);
      reg_rd(8'h30, v);
      check("R7 bad device reads 0", v, 8'h00);
      reg_wr(8'h30, 8'h99);
      reg_wr(8'h07, 8'h00);
      reg_rd(8'h30, v);
      check("R7 bad device write ignored", v, 8'h11);
   endtask

   task automatic t_exit_break;
      logic [7:0] v;
      bus_wr(16'h002E, 8'hAA);
      bus_rd(16'h002F, v);
      check("R4 closed after AAh", v, 8'hFF);
      bus_wr(16'h002E, 8'h87);
      bus_rd(16'h002F, v);
      check("R3 read breaks", v, 8'hFF);
      bus_wr(16'h002E, 8'h87);
      bus_wr(16'h0080, 8'h55);
      bus_wr(16'h002E, 8'h87);
      bus_rd(16'h002F, v);
      check("R3 foreign write breaks", v, 8'hFF);
      open_at(16'h002E);
      reg_rd(8'h20, v);
      check("R2 reopened", v, 8'hA5);
   endtask

   task automatic t_strap;
      logic [7:0] v;
      bus_wr(16'h002E, 8'hAA);
      strap_alt = 1'b1;
      open_at(16'h002E);
      bus_rd(16'h004F, v);
      check("R1 old base inert", v, 8'hFF);
      open_at(16'h004E);
      bus_wr(16'h004E, 8'h20);
      bus_rd(16'h004F, v);
      check("R1 alt data port", v, 8'hA5);
      bus_rd(16'h002F, v);
      check("R1 old data port dead", v, 8'hFF);
      bus_wr(16'h004E, 8'hAA);
      strap_alt = 1'b0;
      open_at(16'h002E);
   endtask

   task automatic t_lock;
      logic [7:0] v;
      reg_wr(8'h26, 8'h20);
      reg_rd(8'h26, v);
      check("R9 lock set", v, 8'h20);
      reg_wr(8'h20, 8'h11);
      reg_rd(8'h20, v);
      check("R9 global blocked", v, 8'hA5);
      reg_wr(8'h07, 8'h05);
      reg_rd(8'h07, v);
      check("R9 select blocked", v, 8'h00);
      reg_wr(8'h26, 8'h00);
      reg_wr(8'h20, 8'h11);
      reg_rd(8'h20, v);
      check("R9 lock released", v, 8'h11);
   endtask

   task automatic t_resets;
      logic [7:0] v;
      @(negedge clk); warm_rst_n = 1'b0;
      repeat (2) @(negedge clk); warm_rst_n = 1'b1;
      check("R11 warm reset value", io_rdata, 8'hFF);
      bus_rd(16'h002F, v);
      check("R10 warm closes", v, 8'hFF);
      open_at(16'h002E);
      bus_rd(16'h002F, v);
      check("R10 warm clears index", v, 8'h00);
      reg_rd(8'h20, v);
      check("R10 warm keeps regs", v, 8'h11);
      @(negedge clk); cold_rst_n = 1'b0;
      repeat (2) @(negedge clk); cold_rst_n = 1'b1;
      open_at(16'h002E);
      reg_rd(8'h20, v);
      check("R10 cold clears global", v, 8'h00);
      reg_rd(8'h02, v);
      check("R10 cold clears 02h", v, 8'h00);
      reg_rd(8'h30, v);
      check("R10 cold clears bank", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cold_rst_n = 1'b1;
      warm_rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_global;
      t_unimpl;
      t_banked;
      t_exit_break;
      t_strap;
      t_lock;
      t_resets;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule